// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block turns one vector load command into the ordered stream of memory read requests that the load needs. A command carries a scalar base address, an element size in bytes, an addressing mode (unit stride or constant stride), a scalar stride value, a segment count, a vector length, a first destination register, a destination predicate with enable and invert controls, and an optional per-element offset vector. The command is captured in full on a start pulse while the block is idle.

Each element that the predicate leaves active produces one request per segment field. Every request carries a byte address, the destination register that the returned data belongs in, and the element index. Requests leave over a valid/ready port, ordered by element first and then by ascending field number. Elements that the predicate masks out produce no request and take no cycle. A one-cycle done pulse marks the end of the command. Returning data, alignment checks and packing of narrow elements into wide lanes are handled elsewhere.

When the offset vector is marked as in use, element i takes its offset from entry i of that vector, which gives a gather. Otherwise the offset is computed from the element number, the segment count and the stride.

Top module: `vec_load_agen`

## Requirements
- R1: With `strided` low, the effective stride equals `elem_bytes` (zero-extended); with `strided` high, the effective stride is `stride_val`.
- R2: With `idx_vec` low, element i has offset i × (seg_len+1) × stride.
- R3: With `idx_vec` high, element i has offset equal to slice i of `idx_offs` (bits i×AW+AW-1 down to i×AW), captured at start.
- R4: Field j of element i (0 ≤ j ≤ seg_len) is requested at base + offset + j × stride, with `req_reg` = rd + j modulo 2^REGW and `req_elem` = i.
- R5: With `pred_en` high, element i < vl is requested only when `pred_bits[i]` XOR `pred_inv` is 1; masked elements issue nothing.
- R6: With `pred_en` low, every element 0..vl-1 is requested regardless of `pred_bits` and `pred_inv`, and no element at or above vl is ever requested.
- R7: Requests are issued by ascending element index, and within an element by ascending field j.
- R8: While `req_valid` is high and `req_ready` is low, the request stays valid and its address, register and element are held unchanged.
- R9: `done` is high for exactly one cycle, in the cycle after the final request is accepted; a command with vl = 0, or with every element masked, raises `done` in the cycle after start and issues no request.
- R10: All address arithmetic wraps modulo 2^AW, and no alignment check is made.
- R11: A start pulse that arrives while `busy` is high is ignored, and the command in progress continues unchanged.
- R12: After reset `busy`, `req_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture a new command when idle |
| base_addr | input | AW | Scalar base byte address |
| elem_bytes | input | EBW | Element size in bytes (unit-stride step) |
| strided | input | 1 | 0 = unit stride, 1 = constant stride from `stride_val` |
| stride_val | input | AW | Scalar stride in bytes |
| seg_len | input | SEGW | Fields per element minus one |
| vl | input | VLW | Vector length, 0..VLMAX |
| rd | input | REGW | First destination register |
| pred_en | input | 1 | Destination predicate enabled |
| pred_inv | input | 1 | Invert predicate bits |
| pred_bits | input | VLMAX | Predicate, bit i for element i |
| idx_vec | input | 1 | Use per-element offsets (gather) |
| idx_offs | input | VLMAX×AW | Per-element offsets, element i in slice i |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Request accepted when high with `req_valid` |
| req_addr | output | AW | Request byte address |
| req_reg | output | REGW | Destination register of the request |
| req_elem | output | EW | Element index of the request |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
The assertions take for granted that `vl` never exceeds VLMAX and that the consumer may hold `req_ready` low for any number of cycles; the in-range check on `req_elem` is only meaningful under that bound. The stimulus keeps every vector length between 0 and VLMAX, changes command inputs freely only while the block is busy (to show they are not re-sampled), and drives `req_ready` with an irregular pattern so that stalls land on first, middle and last fields alike.

// File: rtl/vec_load_agen.sv
module vec_load_agen #(
  parameter int AW    = 32,
  parameter int VLMAX = 8,
  parameter int SEGW  = 3,
  parameter int REGW  = 5,
  parameter int EBW   = 8,
  localparam int VLW  = $clog2(VLMAX + 1),
  localparam int EW   = $clog2(VLMAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [AW-1:0]      base_addr,
  input  logic [EBW-1:0]     elem_bytes,
  input  logic               strided,
  input  logic [AW-1:0]      stride_val,
  input  logic [SEGW-1:0]    seg_len,
  input  logic [VLW-1:0]     vl,
  input  logic [REGW-1:0]    rd,
  input  logic               pred_en,
  input  logic               pred_inv,
  input  logic [VLMAX-1:0]   pred_bits,
  input  logic               idx_vec,
  input  logic [VLMAX*AW-1:0] idx_offs,
  output logic               busy,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [AW-1:0]      req_addr,
  output logic [REGW-1:0]    req_reg,
  output logic [EW-1:0]      req_elem,
  output logic               done
);

  localparam logic [EW:0] NONE = (EW+1)'(VLMAX);

  logic [AW-1:0]    base_q, stride_q;
  logic [SEGW-1:0]  seg_q;
  logic [VLW-1:0]   vl_q;
  logic [REGW-1:0]  rd_q;
  logic             pen_q, pinv_q, idx_q;
  logic [VLMAX-1:0] pbits_q, act_q, act_in;
  logic [AW-1:0]    idx_arr [VLMAX];
  logic [EW-1:0]    e_q;
  logic [SEGW-1:0]  j_q;
  logic [EW:0]      first, nxt;
  logic [AW-1:0]    elem_off;
  logic             accept;

  function automatic logic [EW:0] seek(input logic [VLMAX-1:0] m, input int from);
    logic [EW:0] r;
    r = NONE;
    for (int i = VLMAX - 1; i >= 0; i--)
      if (m[i] && i >= from) r = (EW+1)'(i);
    return r;
  endfunction

  always_comb
    for (int i = 0; i < VLMAX; i++)
      act_in[i] = (i < int'(vl)) && (!pred_en || (pred_bits[i] ^ pred_inv));

  assign first     = seek(act_in, 0);
  assign nxt       = seek(act_q, int'(e_q) + 1);
  assign accept    = busy && req_ready;
  assign req_valid = busy;
  assign req_elem  = e_q;
  assign req_reg   = rd_q + REGW'(j_q);
  assign elem_off  = idx_q ? idx_arr[e_q]
                           : AW'(e_q) * (AW'(seg_q) + AW'(1)) * stride_q;
  assign req_addr  = base_q + elem_off + AW'(j_q) * stride_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      e_q      <= '0;
      j_q      <= '0;
      base_q   <= '0;
      stride_q <= '0;
      seg_q    <= '0;
      vl_q     <= '0;
      rd_q     <= '0;
      pen_q    <= 1'b0;
      pinv_q   <= 1'b0;
      idx_q    <= 1'b0;
      pbits_q  <= '0;
      act_q    <= '0;
      for (int i = 0; i < VLMAX; i++) idx_arr[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        base_q   <= base_addr;
        stride_q <= strided ? stride_val : AW'(elem_bytes);
        seg_q    <= seg_len;
        vl_q     <= vl;
        rd_q     <= rd;
        pen_q    <= pred_en;
        pinv_q   <= pred_inv;
        idx_q    <= idx_vec;
        pbits_q  <= pred_bits;
        act_q    <= act_in;
        for (int i = 0; i < VLMAX; i++) idx_arr[i] <= idx_offs[i*AW +: AW];
        j_q <= '0;
        if (first == NONE) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          e_q  <= first[EW-1:0];
        end
      end else if (accept) begin
        if (j_q != seg_q) begin
          j_q <= j_q + 1'b1;
        end else if (nxt == NONE) begin
          busy <= 1'b0;
          done <= 1'b1;
          j_q  <= '0;
        end else begin
          e_q <= nxt[EW-1:0];
          j_q <= '0;
        end
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_elem));

  assert_pred_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!pen_q || (pbits_q[req_elem] ^ pinv_q)));

  assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_elem} < vl_q));

  assert_field_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (j_q != seg_q) |=> req_valid && req_elem == $past(req_elem) && j_q == $past(j_q) + 1'b1);

  assert_elem_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (j_q == seg_q) && !done |=> !req_valid || (req_elem > $past(req_elem)));

  assert_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && vl == '0 |=> done && !req_valid);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid && $past(!busy || req_ready));

endmodule

// File: tb/test_vec_load_agen.sv
`timescale 1ns/1ps
module test_vec_load_agen;
  localparam int AW = 32, VLMAX = 8, SEGW = 3, REGW = 5, EBW = 8;
  localparam int VLW = $clog2(VLMAX + 1), EW = $clog2(VLMAX);

  typedef struct packed {
    logic [31:0] base;
    logic [7:0]  esz;
    logic        strided;
    logic [31:0] stride;
    logic [2:0]  seg;
    logic [3:0]  vl;
    logic [4:0]  rd;
    logic        pen;
    logic        pinv;
    logic [7:0]  pbits;
    logic        idxv;
    logic [31:0] iseed;
    logic        poke;
    logic [6:0]  nexp;
  } case_t;

  // base, esz, strided, stride, seg, vl, rd, pen, pinv, pbits, idxv, iseed, poke, expected requests
  localparam case_t CASES [9] = '{
    '{32'h0000_1000, 8'd4, 1'b0, 32'h0000_0100, 3'd0, 4'd8, 5'd3,  1'b0, 1'b0, 8'h00, 1'b0, 32'h0, 1'b0, 7'd8},  // R1 R6
    '{32'h0000_2000, 8'd4, 1'b1, 32'd12,        3'd1, 4'd5, 5'd8,  1'b1, 1'b0, 8'h16, 1'b0, 32'h0, 1'b0, 7'd6},  // R2 R4 R5
    '{32'h0000_0010, 8'd4, 1'b1, 32'hFFFF_FFF8, 3'd2, 4'd3, 5'd30, 1'b0, 1'b0, 8'hFF, 1'b0, 32'h0, 1'b0, 7'd9},  // R10 R4 wrap
    '{32'h0000_4000, 8'd8, 1'b0, 32'h0,         3'd1, 4'd6, 5'd1,  1'b1, 1'b1, 8'h05, 1'b1, 32'h300, 1'b0, 7'd8}, // R3 R5 invert
    '{32'h0000_5000, 8'd2, 1'b0, 32'h0,         3'd0, 4'd0, 5'd2,  1'b0, 1'b0, 8'hFF, 1'b0, 32'h0, 1'b0, 7'd0},  // R9 vl 0
    '{32'h0000_6000, 8'd2, 1'b0, 32'h0,         3'd1, 4'd4, 5'd2,  1'b1, 1'b0, 8'hF0, 1'b0, 32'h0, 1'b0, 7'd0},  // R9 all masked
    '{32'hFFFF_FFF0, 8'd8, 1'b0, 32'h0,         3'd0, 4'd4, 5'd9,  1'b0, 1'b0, 8'h00, 1'b0, 32'h0, 1'b0, 7'd4},  // R10 R1
    '{32'h0000_8000, 8'd4, 1'b1, 32'd16,        3'd0, 4'd8, 5'd16, 1'b0, 1'b0, 8'h00, 1'b1, 32'hFFFF_FF80, 1'b0, 7'd8}, // R3
    '{32'h0000_9000, 8'd1, 1'b1, 32'd3,         3'd1, 4'd7, 5'd20, 1'b0, 1'b1, 8'h00, 1'b0, 32'h0, 1'b1, 7'd14}  // R6 R11
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0, stride_val = '0;
  logic [EBW-1:0] elem_bytes = '0;
  logic strided = 0, pred_en = 0, pred_inv = 0, idx_vec = 0, req_ready = 0;
  logic [SEGW-1:0] seg_len = '0;
  logic [VLW-1:0] vl = '0;
  logic [REGW-1:0] rd = '0;
  logic [VLMAX-1:0] pred_bits = '0;
  logic [VLMAX*AW-1:0] idx_offs = '0;
  logic busy, req_valid, done;
  logic [AW-1:0] req_addr;
  logic [REGW-1:0] req_reg;
  logic [EW-1:0] req_elem;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  vec_load_agen #(.AW(AW), .VLMAX(VLMAX), .SEGW(SEGW), .REGW(REGW), .EBW(EBW)) i_vec_load_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .elem_bytes(elem_bytes),
    .strided(strided), .stride_val(stride_val), .seg_len(seg_len), .vl(vl), .rd(rd),
    .pred_en(pred_en), .pred_inv(pred_inv), .pred_bits(pred_bits), .idx_vec(idx_vec),
    .idx_offs(idx_offs), .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_reg(req_reg), .req_elem(req_elem), .done(done));

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_of(input case_t t, input int i);
    return t.iseed - 32'(i) * 32'd24;
  endfunction

  task automatic run_case(input int c);
    case_t t;
    logic [31:0] ea [64];
    logic [4:0]  er [64];
    int          ee [64];
    int n, k;
    bit got_done, stall;
    logic [31:0] s, off, pa;
    logic [4:0] pr;
    logic [EW-1:0] pe;
    t = CASES[c];
    s = t.strided ? t.stride : {24'h0, t.esz};
    n = 0;
    for (int i = 0; i < int'(t.vl); i++) begin
      if (!t.pen || (t.pbits[i] ^ t.pinv)) begin
        off = t.idxv ? idx_of(t, i) : 32'(i) * (32'(t.seg) + 32'd1) * s;
        for (int j = 0; j <= int'(t.seg); j++) begin
          ea[n] = t.base + off + 32'(j) * s;
          er[n] = t.rd + 5'(j);
          ee[n] = i;
          n++;
        end
      end
    end
    base_addr = t.base; elem_bytes = t.esz; strided = t.strided; stride_val = t.stride;
    seg_len = t.seg; vl = t.vl; rd = t.rd; pred_en = t.pen; pred_inv = t.pinv;
    pred_bits = t.pbits; idx_vec = t.idxv;
    for (int i = 0; i < VLMAX; i++) idx_offs[i*AW +: AW] = idx_of(t, i);
    start = 1;
    @(negedge clk);
    start = 0;
    k = 0; got_done = 0; stall = 0; pa = '0; pr = '0; pe = '0;
    for (int cyc = 0; cyc < 400 && !got_done; cyc++) begin
      if (done) begin
        chk(k == n && n == int'(t.nexp), $sformatf("R9 R5 R6 request count case %0d", c), 32'(k), 32'(t.nexp));
        chk(!req_valid, $sformatf("R9 valid with done case %0d", c), 32'(req_valid), 0);
        got_done = 1;
      end else begin
        if (stall) begin
          chk(req_valid && req_addr == pa && req_reg == pr && req_elem == pe,
              $sformatf("R8 hold under stall case %0d", c), req_addr, pa);
        end
        if (req_valid) begin
          if (k < n) begin
            chk(req_addr == ea[k], $sformatf("R1 R2 R3 R4 R10 address case %0d req %0d", c, k), req_addr, ea[k]);
            chk(req_reg == er[k], $sformatf("R4 register case %0d req %0d", c, k), 32'(req_reg), 32'(er[k]));
            chk(int'(req_elem) == ee[k], $sformatf("R7 R5 element case %0d req %0d", c, k), 32'(req_elem), 32'(ee[k]));
          end else begin
            chk(0, $sformatf("R5 R6 extra request case %0d", c), 32'(k), 32'(n));
          end
        end
        req_ready = ((cyc * 5 + c) % 3) != 0;
        stall = req_valid && !req_ready;
        pa = req_addr; pr = req_reg; pe = req_elem;
        if (req_valid && req_ready) k++;
        if (t.poke && (cyc == 1 || cyc == 6)) begin
          start = 1;
          base_addr = 32'hDEAD_0000; stride_val = 32'd1000; vl = 4'd2; rd = 5'd0;
          for (int i = 0; i < VLMAX; i++) idx_offs[i*AW +: AW] = '0;
        end else begin
          start = 0;
        end
        @(negedge clk);
      end
    end
    chk(got_done, $sformatf("R9 done seen case %0d", c), 32'(got_done), 1);
    start = 0;
    req_ready = 0;
    @(negedge clk);
    chk(!done && !busy && !req_valid, $sformatf("R9 single-cycle done case %0d", c), 32'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(!busy && !req_valid && !done, "R12 reset state", {29'h0, busy, req_valid, done}, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !req_valid && !done, "R12 idle after reset", {29'h0, busy, req_valid, done}, 0);
    for (int c = 0; c < 9; c++) run_case(c);
    // R9 back-to-back empty command directly after a full one
    run_case(4);
    run_case(0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule